// File: doc/BRIEF.md
# Link Ownership Arbiter

This block decides which agent may use a shared link between two processors. Up to 64 agents each have a 6-bit identity. An agent sends an 8-bit command byte with a one-cycle strobe. The top two bits choose the kind of command and the low six bits carry either the agent's identity or a transfer reason. On the next cycle the block returns a one-cycle response. The response carries a grant bit, which stands for carry set, or leaves grant low, which means busy or refused. It may also carry a fault bit.

Ownership is exclusive. A claim succeeds only while the link is free, or when the owner claims again. A busy answer tells the agent to try again later. Only the current owner can give the link up. A transfer command is valid only while someone holds the link. The execute reason frees the link without a separate release. The block drives the owner identity and a flag that marks an owner taken from the low system range. The data movement itself is handled elsewhere.

Top module: `link_own_arb`

## Requirements
- R1: Every command strobe gives exactly one response strobe `rsp_valid` on the next clock cycle. `rsp_ok` and `rsp_err` are never high together.
- R2: A claim (bits 7:6 = 2'b11, agent identity in bits 5:0) while the link is free returns `rsp_ok`=1. After that, `link_owned`=1 and `owner_id` holds that identity.
- R3: A claim from any other identity while the link is owned returns `rsp_ok`=0 and `rsp_err`=0, and the owner stays unchanged.
- R4: A claim by the current owner returns `rsp_ok`=1 and leaves ownership unchanged.
- R5: A release (bits 7:6 = 2'b10, identity in bits 5:0) whose identity matches the owner returns `rsp_ok`=1 and frees the link.
- R6: A release from any other identity, or a release while the link is free, is ignored. It returns `rsp_ok`=0 and `rsp_err`=0, and ownership is unchanged.
- R7: A transfer (bits 7:6 = 2'b00, reason in bits 5:0) with a reason other than 4 returns `rsp_ok`=1 while the link is owned, and ownership is kept.
- R8: A transfer with reason 4 (execute) while the link is owned returns `rsp_ok`=1 and frees the link.
- R9: Any transfer while the link is free returns `rsp_err`=1 and `rsp_ok`=0, and the link stays free.
- R10: A command with bits 7:6 = 2'b01 is ignored. It returns `rsp_ok`=0 and `rsp_err`=0, and ownership is unchanged.
- R11: After reset the link is free, `owner_id` is 0, and no response is pending.
- R12: `owner_sys` is 1 exactly when the link is owned and `owner_id` is below 4, the system range. Identities 4 to 63 are user agents.
- R13: Without a command strobe, `link_owned` and `owner_id` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_byte | input | 8 | Command: kind in bits 7:6, identity or reason in bits 5:0 |
| rsp_valid | output | 1 | Response strobe, one cycle after the command |
| rsp_ok | output | 1 | Grant / carry set |
| rsp_err | output | 1 | Transfer attempted while the link was free |
| link_owned | output | 1 | Link currently held |
| owner_id | output | 6 | Identity of the holder |
| owner_sys | output | 1 | Holder is in the system identity range |

## Verification
The bench builds the block with its default parameters: a 6-bit identity, execute reason 4, and four system identities. With these values the highest identity (63), the system range boundary (identities 2 and 4), and the execute reason are all exercised directly. Commands are sent back to back so that each ownership change is seen by the very next command. The sequences include re-claims by the owner, releases from strangers, transfers on a free link, and the unused command kind.

// File: rtl/link_own_pkg.sv
package link_own_pkg;
    typedef enum logic [1:0] {
        OP_XFER  = 2'b00,
        OP_RSVD  = 2'b01,
        OP_FREE  = 2'b10,
        OP_CLAIM = 2'b11
    } op_e;
endpackage

// File: rtl/link_own_decode.sv
module link_own_decode
    import link_own_pkg::*;
#(
    parameter int ID_W        = 6,
    parameter int EXEC_REASON = 4
) (
    input  logic [ID_W+1:0] cmd_byte,
    output op_e             op,
    output logic [ID_W-1:0] field,
    output logic            is_exec
);
    localparam int CMD_W = ID_W + 2;

    always_comb begin
        op      = op_e'(cmd_byte[CMD_W-1 -: 2]);
        field   = cmd_byte[ID_W-1:0];
        is_exec = (op == OP_XFER) && (field == ID_W'(EXEC_REASON));
    end
endmodule

// File: rtl/link_own_state.sv
module link_own_state
    import link_own_pkg::*;
#(
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  op_e             op,
    input  logic [ID_W-1:0] field,
    input  logic            is_exec,
    output logic            owned,
    output logic [ID_W-1:0] owner,
    output logic            grant,
    output logic            fault
);
    typedef struct packed {
        logic            owned;
        logic [ID_W-1:0] owner;
    } own_t;

    own_t st_d, st_q;
    logic same_id;

    always_comb begin
        st_d    = st_q;
        grant   = 1'b0;
        fault   = 1'b0;
        same_id = st_q.owned && (st_q.owner == field);
        if (cmd_valid) begin
            unique case (op)
                OP_CLAIM: begin
                    if (!st_q.owned) begin
                        st_d.owned = 1'b1;
                        st_d.owner = field;
                        grant      = 1'b1;
                    end else if (same_id) begin
                        grant = 1'b1;
                    end
                end
                OP_FREE: begin
                    if (same_id) begin
                        st_d.owned = 1'b0;
                        grant      = 1'b1;
                    end
                end
                OP_XFER: begin
                    if (st_q.owned) begin
                        grant = 1'b1;
                        if (is_exec) st_d.owned = 1'b0;
                    end else begin
                        fault = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owned = st_q.owned;
    assign owner = st_q.owner;
endmodule

// File: rtl/link_own_rsp.sv
module link_own_rsp (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic grant,
    input  logic fault,
    output logic rsp_valid,
    output logic rsp_ok,
    output logic rsp_err
);
    typedef struct packed {
        logic vld;
        logic ok;
        logic err;
    } rsp_t;

    rsp_t r_d, r_q;

    always_comb begin
        r_d.vld = cmd_valid;
        r_d.ok  = cmd_valid && grant;
        r_d.err = cmd_valid && fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = r_q.vld;
    assign rsp_ok    = r_q.ok;
    assign rsp_err   = r_q.err;
endmodule

// File: rtl/link_own_arb.sv
module link_own_arb
    import link_own_pkg::*;
#(
    parameter int ID_W        = 6,
    parameter int EXEC_REASON = 4,
    parameter int NUM_SYS_IDS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [ID_W+1:0] cmd_byte,
    output logic            rsp_valid,
    output logic            rsp_ok,
    output logic            rsp_err,
    output logic            link_owned,
    output logic [ID_W-1:0] owner_id,
    output logic            owner_sys
);
    op_e             op;
    logic [ID_W-1:0] field;
    logic            is_exec;
    logic            grant;
    logic            fault;

    link_own_decode #(.ID_W(ID_W), .EXEC_REASON(EXEC_REASON)) dec_i (
        .cmd_byte (cmd_byte),
        .op       (op),
        .field    (field),
        .is_exec  (is_exec)
    );

    link_own_state #(.ID_W(ID_W)) st_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .op        (op),
        .field     (field),
        .is_exec   (is_exec),
        .owned     (link_owned),
        .owner     (owner_id),
        .grant     (grant),
        .fault     (fault)
    );

    link_own_rsp rsp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .grant     (grant),
        .fault     (fault),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok),
        .rsp_err   (rsp_err)
    );

    assign owner_sys = link_owned && (owner_id < ID_W'(NUM_SYS_IDS));
endmodule

// File: rtl/link_own_chk.sv
module link_own_chk #(
    parameter int ID_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [ID_W+1:0] cmd_byte,
    input logic            rsp_valid,
    input logic            rsp_ok,
    input logic            rsp_err,
    input logic            link_owned,
    input logic [ID_W-1:0] owner_id
);
    // R1
    rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);
    // R1
    ok_err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ok && rsp_err));
    // R2
    claim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[ID_W+1 -: 2] == 2'b11 && !link_owned)
        |=> (rsp_ok && link_owned && owner_id == $past(cmd_byte[ID_W-1:0])));
    // R3
    claim_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[ID_W+1 -: 2] == 2'b11 && link_owned
         && cmd_byte[ID_W-1:0] != owner_id)
        |=> (!rsp_ok && link_owned && $stable(owner_id)));
    // R6
    stranger_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[ID_W+1 -: 2] == 2'b10 && link_owned
         && cmd_byte[ID_W-1:0] != owner_id)
        |=> (!rsp_ok && link_owned && $stable(owner_id)));
    // R9
    xfer_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[ID_W+1 -: 2] == 2'b00 && !link_owned)
        |=> (rsp_err && !link_owned));
    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(link_owned) && $stable(owner_id)));
endmodule

bind link_own_arb link_own_chk #(.ID_W(ID_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_err    (rsp_err),
    .link_owned (link_owned),
    .owner_id   (owner_id)
);

// File: tb/link_own_arb_tb_top.sv
module link_own_arb_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       rsp_valid, rsp_ok, rsp_err, link_owned, owner_sys;
    logic [5:0] owner_id;

    always #2 clk = ~clk;

    link_own_arb dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .rsp_valid  (rsp_valid),
        .rsp_ok     (rsp_ok),
        .rsp_err    (rsp_err),
        .link_owned (link_owned),
        .owner_id   (owner_id),
        .owner_sys  (owner_sys)
    );

    typedef struct {
        logic       ok;
        logic       err;
        logic       own;
        logic [5:0] id;
        logic       sys;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   m_own  = 1'b0;
    logic [5:0] m_id = '0;
    bit   done   = 1'b0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: model the requirements, push expectation, drive one command.
    task automatic send(input logic [1:0] kind, input logic [5:0] f, input string tag);
        exp_t e;
        e.ok = 1'b0; e.err = 1'b0; e.tag = tag;
        case (kind)
            2'b11: if (!m_own) begin m_own = 1'b1; m_id = f; e.ok = 1'b1; end
                   else if (m_id == f) e.ok = 1'b1;
            2'b10: if (m_own && m_id == f) begin m_own = 1'b0; e.ok = 1'b1; end
            2'b00: if (m_own) begin e.ok = 1'b1; if (f == 6'd4) m_own = 1'b0; end
                   else e.err = 1'b1;
            default: ;
        endcase
        e.own = m_own; e.id = m_id;
        e.sys = m_own && (m_id < 6'd4);
        exp_q.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = {kind, f};
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare as responses appear.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected response", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " ok/err"}, {14'd0, rsp_ok, rsp_err}, {14'd0, e.ok, e.err});
                check({e.tag, " owner"}, {9'd0, link_owned, owner_id}, {9'd0, e.own, e.id});
                check("R12 owner_sys", {15'd0, owner_sys}, {15'd0, e.sys});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check("watchdog expired", 16'd1, 16'd0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset", {13'd0, rsp_valid, link_owned, owner_sys}, 16'd0);
        check("R11 owner_id", {10'd0, owner_id}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        send(2'b11, 6'd5,  "R2 claim free");
        send(2'b11, 6'd9,  "R3 claim busy");
        send(2'b11, 6'd5,  "R4 reclaim by owner");
        send(2'b10, 6'd9,  "R6 stranger release");
        send(2'b00, 6'd1,  "R7 transfer owned");
        send(2'b01, 6'd5,  "R10 reserved kind");
        send(2'b10, 6'd5,  "R5 owner release");
        send(2'b10, 6'd5,  "R6 release when free");
        send(2'b00, 6'd4,  "R9 exec when free");
        send(2'b00, 6'd2,  "R9 transfer when free");
        send(2'b11, 6'd2,  "R2 claim system id");
        send(2'b00, 6'd4,  "R8 execute frees");
        send(2'b11, 6'd4,  "R12 claim first user id");
        idle(3);
        // R13 hold while idle
        check("R13 hold owned", {10'd0, owner_id}, 16'd4);
        check("R13 no response", {15'd0, rsp_valid}, 16'd0);
        send(2'b00, 6'd5,  "R7 reason 5 keeps");
        send(2'b10, 6'd4,  "R5 release user");
        send(2'b11, 6'd63, "R2 claim top id");
        send(2'b11, 6'd0,  "R3 claim id 0 busy");
        send(2'b00, 6'd63, "R7 reason 63");
        send(2'b10, 6'd63, "R5 release top id");
        idle(4);
        check("R1 queue drained", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule